// File: doc/BRIEF.md
# Microsequenced Accumulator Processor

This block is a small 8-bit processor built around one accumulator and a private 16-byte memory. Each instruction fills one byte. The high nibble selects the operation and the low nibble names a memory location. Every instruction is carried out as a chain of register transfers, with one transfer per clock. A step counter advances through the transfers and a decoder turns the current step and the operation code into a set of write enables. The datapath holds the following registers:

- a memory address register and a memory buffer register in front of the RAM;
- a program counter;
- an instruction register;
- the accumulator;
- an adder/subtractor that produces zero and carry flags.

Software gets into the block in one way only. While reset is held high, bytes presented on the preload port are written straight into the RAM. When reset falls, execution starts at address 0. The processor then runs until it meets a halt instruction, and it stays frozen until the next reset. The accumulator, program counter, flags and halt state are visible on output ports at all times.

Top module: `acpu_core`

## Requirements
- R1: While `rst` is high, `pc`, `acc`, `zero`, `carry` and `halted` all read 0.
- R2: While `rst` is high, a cycle with `pre_we` high writes `pre_data` into the RAM location `pre_addr`. Memory contents are not cleared by reset.
- R3: Opcode 0x0 (halt) raises `halted` on the 4th rising edge after reset falls when it sits at address 0, and it leaves `pc` at 1. Afterwards `halted`, `pc` and `acc` do not change until reset.
- R4: Opcode 0x1 loads the byte at the address field into `acc`. It takes 6 clocks including fetch and leaves `zero` and `carry` unchanged.
- R5: Opcode 0x2 reads the byte at the address field. It uses the low 4 bits of that byte as a second address and loads the byte there into `acc`.
- R6: Opcode 0x3 stores `acc` to the address field in 6 clocks.
- R7: Opcode 0x4 reads a pointer from the address field and stores `acc` to the location in the pointer's low 4 bits. It takes 8 clocks.
- R8: Opcode 0x5 sets `acc` to `acc` + mem[addr] modulo 256, with `carry` equal to the carry out of bit 7 and `zero` high when the result is 0. It takes 6 clocks.
- R9: Opcode 0x6 sets `acc` to `acc` − mem[addr] modulo 256, with `carry` high when mem[addr] > `acc` (borrow) and `zero` high when the result is 0. It takes 6 clocks.
- R10: Opcode 0x7 loads `pc` with the address field. It takes 4 clocks.
- R11: Opcode 0x8 loads `pc` with the address field only when `zero` is high. Otherwise `pc` keeps the value it was incremented to during fetch. Both cases take 4 clocks.
- R12: Opcodes 0x9 to 0xF change nothing except the fetch's increment of `pc`. Each takes 4 clocks.
- R13: Fetch uses three steps (address, read with `pc` increment, decode). `pc` is 4 bits wide and wraps from 15 to 0.
- R14: The loop "load 4, add 5, store 4, jump 0", with data bytes 0 at address 4 and 1 at address 5, takes 22 clocks per pass. After k passes `acc` equals k mod 256. On the pass that wraps 255 to 0, both `zero` and `carry` go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also enables preload |
| pre_we | input | 1 | Preload write strobe, honoured only during reset |
| pre_addr | input | 4 | Preload target address |
| pre_data | input | 8 | Preload byte |
| halted | output | 1 | High once a halt instruction has executed |
| acc | output | 8 | Accumulator |
| pc | output | 4 | Program counter |
| zero | output | 1 | Zero flag from the last add or subtract |
| carry | output | 1 | Carry/borrow flag from the last add or subtract |

## Verification
The bench samples the accumulator and program counter at exact clock counts, so every instruction's cycle budget is checked. A sequencer that adds or drops a step shifts these values and the samples no longer match. The indirect load and store tests place the pointer and the target at different addresses. A design that treats the pointer as the operand therefore ends with the wrong accumulator value. A subtract below zero and an add that wraps to exactly zero test the borrow and zero flags, and a load that follows a zero result checks that loads leave the flags alone. Two further tests cover control flow and the PC. Conditional jumps are run both taken and not taken, and each wrong branch ends at a different halt address. A straight line of undefined opcodes must step `pc` through 15 back to 0 and leave `acc` untouched.

// File: rtl/acpu_pkg.sv
package acpu_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int OP_W   = DATA_W - ADDR_W;
    localparam int STEP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_HLT = 4'h0,
        OP_LDA = 4'h1,
        OP_LDI = 4'h2,
        OP_STA = 4'h3,
        OP_STI = 4'h4,
        OP_ADD = 4'h5,
        OP_SUB = 4'h6,
        OP_JMP = 4'h7,
        OP_JPZ = 4'h8
    } opcode_e;

    typedef enum logic [1:0] {MAR_HOLD, MAR_PC, MAR_IR, MAR_MBR} mar_src_e;
    typedef enum logic [1:0] {MBR_HOLD, MBR_MEM, MBR_ACC}        mbr_src_e;
    typedef enum logic [1:0] {ACC_HOLD, ACC_MBR, ACC_ALU}        acc_src_e;

    // One micro-command: the register transfers enabled in a single step
    typedef struct packed {
        mar_src_e mar;
        mbr_src_e mbr;
        acc_src_e acc;
        logic     ir_we;
        logic     pc_inc;
        logic     pc_load;
        logic     mem_we;
        logic     flag_we;
        logic     alu_sub;
        logic     halt;
        logic     step_clr;
    } uop_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              zero;
        logic              carry;
    } alu_res_t;

    function automatic uop_t uop_idle();
        uop_t u;
        u = '0;
        return u;
    endfunction

    // Operations whose execute phase needs an operand fetched from memory
    function automatic logic reads_operand(opcode_e op);
        return (op == OP_LDA) || (op == OP_LDI) || (op == OP_STI) ||
               (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/acpu_ram.sv
module acpu_ram
    import acpu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Read is registered by the buffer register in the core
    assign rdata = cells[raddr];

endmodule

// File: rtl/acpu_alu.sv
module acpu_alu
    import acpu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    input  logic          sub,
    output alu_res_t      res
);
    logic [DW:0] wide;

    always_comb begin
        if (sub) begin
            wide = {1'b0, lhs} - {1'b0, rhs};
        end else begin
            wide = {1'b0, lhs} + {1'b0, rhs};
        end
        res.value = wide[DW-1:0];
        res.carry = wide[DW];
        res.zero  = (wide[DW-1:0] == '0);
    end

endmodule

// File: rtl/acpu_ctrl.sv
module acpu_ctrl
    import acpu_pkg::*;
#(
    parameter int SW = STEP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  opcode_e       op,
    input  logic          zero,
    output uop_t          uop,
    output logic [SW-1:0] step,
    output logic          halted
);
    localparam logic [SW-1:0] S_ADDR  = SW'(0);
    localparam logic [SW-1:0] S_READ  = SW'(1);
    localparam logic [SW-1:0] S_DEC   = SW'(2);
    localparam logic [SW-1:0] S_EX0   = SW'(3);
    localparam logic [SW-1:0] S_EX1   = SW'(4);
    localparam logic [SW-1:0] S_EX2   = SW'(5);
    localparam logic [SW-1:0] S_EX3   = SW'(6);
    localparam logic [SW-1:0] S_EX4   = SW'(7);

    logic [SW-1:0] step_q;
    logic          halted_q;
    uop_t          dec;

    always_comb begin
        dec = uop_idle();
        case (step_q)
            S_ADDR: dec.mar = MAR_PC;
            S_READ: begin
                dec.mbr    = MBR_MEM;
                dec.pc_inc = 1'b1;
            end
            S_DEC:  dec.ir_we = 1'b1;
            S_EX0: begin
                if (reads_operand(op) || op == OP_STA) begin
                    dec.mar = MAR_IR;
                end else begin
                    dec.step_clr = 1'b1;
                    case (op)
                        OP_HLT:  dec.halt    = 1'b1;
                        OP_JMP:  dec.pc_load = 1'b1;
                        OP_JPZ:  dec.pc_load = zero;
                        default: ;
                    endcase
                end
            end
            S_EX1: begin
                if (op == OP_STA) begin
                    dec.mbr = MBR_ACC;
                end else if (reads_operand(op)) begin
                    dec.mbr = MBR_MEM;
                end else begin
                    dec.step_clr = 1'b1;
                end
            end
            S_EX2: begin
                case (op)
                    OP_LDA: begin
                        dec.acc      = ACC_MBR;
                        dec.step_clr = 1'b1;
                    end
                    OP_LDI, OP_STI: dec.mar = MAR_MBR;
                    OP_STA: begin
                        dec.mem_we   = 1'b1;
                        dec.step_clr = 1'b1;
                    end
                    OP_ADD, OP_SUB: begin
                        dec.acc      = ACC_ALU;
                        dec.flag_we  = 1'b1;
                        dec.alu_sub  = (op == OP_SUB);
                        dec.step_clr = 1'b1;
                    end
                    default: dec.step_clr = 1'b1;
                endcase
            end
            S_EX3: begin
                case (op)
                    OP_LDI:  dec.mbr = MBR_MEM;
                    OP_STI:  dec.mbr = MBR_ACC;
                    default: dec.step_clr = 1'b1;
                endcase
            end
            S_EX4: begin
                dec.step_clr = 1'b1;
                case (op)
                    OP_LDI:  dec.acc    = ACC_MBR;
                    OP_STI:  dec.mem_we = 1'b1;
                    default: ;
                endcase
            end
            default: dec.step_clr = 1'b1;
        endcase
    end

    // A halted machine issues no transfers at all
    assign uop = halted_q ? uop_idle() : dec;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q   <= S_ADDR;
            halted_q <= 1'b0;
        end else if (!halted_q) begin
            step_q   <= dec.step_clr ? S_ADDR : step_q + SW'(1);
            halted_q <= dec.halt;
        end
    end

    assign step   = step_q;
    assign halted = halted_q;

endmodule

// File: rtl/acpu_core.sv
module acpu_core
    import acpu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    output logic          halted,
    output logic [DW-1:0] acc,
    output logic [AW-1:0] pc,
    output logic          zero,
    output logic          carry
);
    logic [AW-1:0]     pc_q;
    logic [AW-1:0]     mar_q;
    logic [DW-1:0]     mbr_q;
    logic [DW-1:0]     ir_q;
    logic [DW-1:0]     acc_q;
    logic              zero_q;
    logic              carry_q;

    logic [STEP_W-1:0] step_w;
    logic              halted_w;
    uop_t              uop;
    alu_res_t          alu_res;
    opcode_e           op_w;
    logic [AW-1:0]     ir_addr;

    logic              ram_we;
    logic [AW-1:0]     ram_waddr;
    logic [DW-1:0]     ram_wdata;
    logic [DW-1:0]     ram_rdata;

    assign op_w    = opcode_e'(ir_q[DW-1:AW]);
    assign ir_addr = ir_q[AW-1:0];

    acpu_ctrl #(.SW(STEP_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .op     (op_w),
        .zero   (zero_q),
        .uop    (uop),
        .step   (step_w),
        .halted (halted_w)
    );

    acpu_alu #(.DW(DW)) u_alu (
        .lhs (acc_q),
        .rhs (mbr_q),
        .sub (uop.alu_sub),
        .res (alu_res)
    );

    // Preload owns the write port while reset is held
    assign ram_we    = rst ? pre_we   : uop.mem_we;
    assign ram_waddr = rst ? pre_addr : mar_q;
    assign ram_wdata = rst ? pre_data : mbr_q;

    acpu_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (mar_q),
        .rdata (ram_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            mar_q   <= '0;
            mbr_q   <= '0;
            ir_q    <= '0;
            acc_q   <= '0;
            zero_q  <= 1'b0;
            carry_q <= 1'b0;
        end else begin
            case (uop.mar)
                MAR_PC:  mar_q <= pc_q;
                MAR_IR:  mar_q <= ir_addr;
                MAR_MBR: mar_q <= mbr_q[AW-1:0];
                default: ;
            endcase
            case (uop.mbr)
                MBR_MEM: mbr_q <= ram_rdata;
                MBR_ACC: mbr_q <= acc_q;
                default: ;
            endcase
            if (uop.ir_we) begin
                ir_q <= mbr_q;
            end
            if (uop.pc_load) begin
                pc_q <= ir_addr;
            end else if (uop.pc_inc) begin
                pc_q <= pc_q + AW'(1);
            end
            case (uop.acc)
                ACC_MBR: acc_q <= mbr_q;
                ACC_ALU: acc_q <= alu_res.value;
                default: ;
            endcase
            if (uop.flag_we) begin
                zero_q  <= alu_res.zero;
                carry_q <= alu_res.carry;
            end
        end
    end

    assign halted = halted_w;
    assign acc    = acc_q;
    assign pc     = pc_q;
    assign zero   = zero_q;
    assign carry  = carry_q;

endmodule

// File: rtl/acpu_core_chk.sv
module acpu_core_chk
    import acpu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              halted,
    input logic [DW-1:0]     acc,
    input logic [AW-1:0]     pc,
    input logic              zero,
    input logic              carry,
    input logic [STEP_W-1:0] step,
    input logic [OP_W-1:0]   op,
    input logic [AW-1:0]     ir_addr
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pc == '0 && acc == '0 && !zero && !carry && !halted));

    p_halt_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc) && $stable(acc) && $stable(step)));

    p_flags_only_alu_r4: assert property (@(posedge clk) disable iff (rst)
        !(op == OP_ADD || op == OP_SUB) |=> ($stable(zero) && $stable(carry)));

    p_jump_target_r10: assert property (@(posedge clk) disable iff (rst)
        (!halted && step == 3'd3 && op == OP_JMP) |=> (pc == $past(ir_addr)));

    p_jpz_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!halted && step == 3'd3 && op == OP_JPZ && !zero) |=> $stable(pc));

    p_fetch_increment_r13: assert property (@(posedge clk) disable iff (rst)
        (!halted && step == 3'd1) |=> (pc == AW'($past(pc) + AW'(1))));

endmodule

bind acpu_core acpu_core_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .halted  (halted),
    .acc     (acc),
    .pc      (pc),
    .zero    (zero),
    .carry   (carry),
    .step    (step_w),
    .op      (ir_q[DW-1:AW]),
    .ir_addr (ir_q[AW-1:0])
);

// File: tb/acpu_core_test.sv
module acpu_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_we = 1'b0;
    logic [3:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic       halted;
    logic [7:0] acc;
    logic [3:0] pc;
    logic       zero;
    logic       carry;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    logic [7:0] img [16];

    acpu_core uut (
        .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .halted(halted), .acc(acc), .pc(pc),
        .zero(zero), .carry(carry)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_fails  = n_fails + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 16; i++) img[i] = 8'h00;
    endtask

    // Hold reset, preload the image, release reset on a falling edge
    task automatic boot();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            pre_we   = 1'b1;
            pre_addr = 4'(i);
            pre_data = img[i];
            @(negedge clk);
        end
        pre_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_to_halt(input string req);
        int k = 0;
        while (!halted && k < 2000) begin
            @(negedge clk);
            k++;
        end
        chk(req, 32'(halted), 32'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        run_cycles(3);
        chk("R1 pc", 32'(pc), 32'd0);
        chk("R1 acc", 32'(acc), 32'd0);
        chk("R1 zero", 32'(zero), 32'd0);
        chk("R1 carry", 32'(carry), 32'd0);
        chk("R1 halted", 32'(halted), 32'd0);
    endtask

    task automatic t_halt();
        clear_img();
        boot();
        run_cycles(3);
        chk("R3 not yet halted", 32'(halted), 32'd0);
        run_cycles(1);
        chk("R3 halted on 4th edge", 32'(halted), 32'd1);
        chk("R3 pc after halt", 32'(pc), 32'd1);
        run_cycles(10);
        chk("R3 pc frozen", 32'(pc), 32'd1);
        chk("R3 stays halted", 32'(halted), 32'd1);
    endtask

    task automatic t_load();
        // R2 image loaded via preload; SUB 9 makes zero=1, LDA must keep it
        clear_img();
        img[0] = 8'h69; img[1] = 8'h18; img[2] = 8'h00;
        img[8] = 8'h5A; img[9] = 8'h00;
        boot();
        run_cycles(12);
        chk("R4 lda acc at 6 clocks", 32'(acc), 32'h5A);
        chk("R4 lda keeps zero", 32'(zero), 32'd1);
        run_to_halt("R2 program halts");
        // R5 indirect load through pointer at 10
        clear_img();
        img[0] = 8'h2A; img[10] = 8'h0C; img[12] = 8'h77;
        boot();
        run_cycles(8);
        chk("R5 ldi acc at 8 clocks", 32'(acc), 32'h77);
        run_to_halt("R5 halts");
        chk("R5 pc", 32'(pc), 32'd2);
    endtask

    task automatic t_store();
        clear_img();
        img[0] = 8'h18; img[1] = 8'h39; img[2] = 8'h4A;
        img[3] = 8'h59; img[4] = 8'h5E; img[5] = 8'h00;
        img[8] = 8'h33; img[10] = 8'h0E;
        boot();
        run_cycles(26);
        chk("R6 sta then add", 32'(acc), 32'h66);
        run_cycles(6);
        chk("R7 sti then add", 32'(acc), 32'h99);
        run_to_halt("R7 halts");
    endtask

    task automatic t_alu();
        clear_img();
        img[0] = 8'h18; img[1] = 8'h59; img[2] = 8'h5A; img[3] = 8'h6B;
        img[4] = 8'h6C; img[5] = 8'h5D; img[6] = 8'h00;
        img[8] = 8'hF0; img[9] = 8'h20; img[10] = 8'hF0;
        img[11] = 8'h07; img[12] = 8'hF9; img[13] = 8'h01;
        boot();
        run_cycles(12);
        chk("R8 add overflow acc", 32'(acc), 32'h10);
        chk("R8 add overflow carry", 32'(carry), 32'd1);
        chk("R8 add overflow zero", 32'(zero), 32'd0);
        run_cycles(6);
        chk("R8 add to zero acc", 32'(acc), 32'h00);
        chk("R8 add to zero flags", {30'd0, zero, carry}, 32'd3);
        run_cycles(6);
        chk("R9 sub borrow acc", 32'(acc), 32'hF9);
        chk("R9 sub borrow flags", {30'd0, zero, carry}, 32'd1);
        run_cycles(6);
        chk("R9 sub equal flags", {30'd0, zero, carry}, 32'd2);
        run_cycles(6);
        chk("R8 add small", 32'(acc), 32'h01);
        chk("R8 add small flags", {30'd0, zero, carry}, 32'd0);
        run_to_halt("R8 halts");
    endtask

    task automatic t_jump();
        clear_img();
        img[0] = 8'h75; img[5] = 8'h6F; img[6] = 8'h89;
        img[9] = 8'h5E; img[10] = 8'h8C; img[11] = 8'h00;
        img[14] = 8'h01; img[15] = 8'h00;
        boot();
        run_cycles(4);
        chk("R10 jmp target", 32'(pc), 32'd5);
        run_cycles(10);
        chk("R11 jpz taken", 32'(pc), 32'd9);
        run_to_halt("R11 halts");
        chk("R11 jpz not taken halt pc", 32'(pc), 32'd12);
        chk("R11 acc", 32'(acc), 32'h01);
    endtask

    task automatic t_nop_wrap();
        clear_img();
        img[0] = 8'h1F;
        for (int i = 1; i < 15; i++) img[i] = {4'(9 + (i % 7)), 4'(i)};
        img[15] = 8'hC5;
        boot();
        run_cycles(63);
        chk("R13 pc before wrap", 32'(pc), 32'd15);
        run_cycles(1);
        chk("R13 pc wrapped", 32'(pc), 32'd0);
        run_cycles(2);
        chk("R12 nops keep acc", 32'(acc), 32'hC5);
        chk("R12 nops keep flags", {30'd0, zero, carry}, 32'd0);
        chk("R12 nops no halt", 32'(halted), 32'd0);
    endtask

    task automatic t_counter();
        clear_img();
        img[0] = 8'h14; img[1] = 8'h55; img[2] = 8'h34; img[3] = 8'h70;
        img[4] = 8'h00; img[5] = 8'h01;
        boot();
        run_cycles(22 * 3);
        chk("R14 count 3", 32'(acc), 32'd3);
        chk("R14 pc at loop top", 32'(pc), 32'd0);
        run_cycles(22 * 252);
        chk("R14 count 255", 32'(acc), 32'd255);
        chk("R14 no carry yet", 32'(carry), 32'd0);
        run_cycles(22);
        chk("R14 wrap acc", 32'(acc), 32'd0);
        chk("R14 wrap flags", {30'd0, zero, carry}, 32'd3);
        run_cycles(22);
        chk("R14 restart", 32'(acc), 32'd1);
    endtask

    initial begin
        t_reset();
        t_halt();
        t_load();
        t_store();
        t_alu();
        t_jump();
        t_nop_wrap();
        t_counter();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule